// File: doc/BRIEF.md
# Static LCD Driver for a Three-and-a-Half Digit Reading

This block turns a latched signed reading into the drive lines of a static (non-multiplexed) liquid crystal display. The reading has a leading thousands bit, three BCD digits, a negative flag and an overrange flag. A load strobe captures it, and the captured value then drives the glass until the next strobe.

Every segment line is a square wave at the backplane frequency. A dark segment moves in step with the backplane. A lit segment is its inverse, so the glass never carries a net DC voltage. The leading position is a single line that feeds both right-hand segments of the leftmost digit, so it shows either nothing or a "1". A separate line drives the minus sign. In overrange, the three low digits go dark. A lamp-test input forces every segment on at a constant level, which shows 1888 and the minus sign.

Top module: `lcd_static_drv`

## Requirements
- R1: `bp_o` is a 50% square wave whose period is DIV clock cycles (default 800). After reset it stays low for DIV/2 cycles, then alternates DIV/2 cycles high and DIV/2 cycles low.
- R2: Outside lamp test, every segment output (`seg_o`, `thou_o`, `pol_o`) equals `bp_o` when dark and equals the inverse of `bp_o` when lit.
- R3: Digit k (k=0 is units) drives `seg_o[7k+6:7k]` with bit 0 = segment a through bit 6 = segment g. Codes 0..9 light the patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex), in that order.
- R4: BCD codes 10 to 15 light no segment of their digit.
- R5: `thou_o` is lit when the captured thousands bit is 1 and dark when it is 0.
- R6: `pol_o` is lit when the captured negative flag is 1 and dark when it is 0.
- R7: When the captured overrange flag is 1, all 21 digit segments are dark and `thou_o` is lit. `pol_o` still follows the negative flag.
- R8: While `lamp_i` is high, every segment output is held high, with no toggling, and `bp_o` keeps running. When `lamp_i` falls, the captured reading is shown again.
- R9: The reading is captured on a clock edge where `load_i` is high. Changes on the data inputs without a strobe have no effect on the outputs. Outputs reflect a strobe two clock edges after it.
- R10: While `rst_ni` is low, `bp_o` and all segment outputs are low and the divider is cleared. After reset, all digits, the thousands line and the sign are dark.
- R11: All segment outputs change on the same clock edge as `bp_o`, so a toggle of `bp_o` is matched by a toggle of every segment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture strobe for the reading |
| thou_i | input | 1 | Thousands (leading "1") bit |
| bcd_i | input | 4*DIGITS | BCD digits, units in bits 3:0 |
| neg_i | input | 1 | Reading is negative |
| ovr_i | input | 1 | Reading is out of range |
| lamp_i | input | 1 | Lamp test, all segments on |
| seg_o | output | 7*DIGITS | Digit segment drive, 7 lines per digit |
| thou_o | output | 1 | Leading-one segment drive |
| pol_o | output | 1 | Minus-sign segment drive |
| bp_o | output | 1 | Backplane square wave |

## Verification
A fault in the captured reading shows up within one backplane half-period as a wrong segment phase. It is visible at once on the current phase and again after the next toggle, so each reading is checked at both backplane levels. A divider fault shows as a backplane half-period that is not DIV/2 cycles, and the first full half-period after reset exposes it. If the output stage falls out of step with the backplane, some segment fails to toggle in the cycle where the backplane toggles. Running the segment comparison in that exact cycle catches the skew on its first occurrence.

// File: rtl/lcd_pkg.sv
`timescale 1ns/1ps
package lcd_pkg;
  localparam int SEG_N = 7;
  typedef logic [SEG_N-1:0] seg7_t;

  // bit0 = a ... bit6 = g
  function automatic seg7_t bcd_to_seg7(input logic [3:0] code);
    seg7_t s;
    case (code)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lcd_bp_div.sv
`timescale 1ns/1ps
module lcd_bp_div #(
  parameter int DIV = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bp_nxt_o,
  output logic bp_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          bp_q;
  logic          wrap;

  assign wrap     = (cnt_q == CW'(HALF - 1));
  assign bp_nxt_o = wrap ? ~bp_q : bp_q;
  assign bp_o     = bp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      bp_q  <= bp_nxt_o;
    end
  end
endmodule

// File: rtl/lcd_digit_dec.sv
`timescale 1ns/1ps
module lcd_digit_dec
  import lcd_pkg::*;
(
  input  logic [3:0] code_i,
  input  logic       blank_i,
  output seg7_t      seg_o
);
  assign seg_o = blank_i ? '0 : bcd_to_seg7(code_i);
endmodule

// File: rtl/lcd_phase_drv.sv
`timescale 1ns/1ps
module lcd_phase_drv #(
  parameter int W = 23
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lit_i,
  input  logic         bp_nxt_i,
  input  logic         lamp_i,
  output logic [W-1:0] drv_o
);
  // registered against the next backplane level: same edge as bp
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     drv_o <= '0;
    else if (lamp_i) drv_o <= '1;
    else             drv_o <= lit_i ^ {W{bp_nxt_i}};
  end
endmodule

// File: rtl/lcd_static_drv.sv
`timescale 1ns/1ps
module lcd_static_drv
  import lcd_pkg::*;
#(
  parameter int DIGITS = 3,
  parameter int DIV    = 800
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  thou_i,
  input  logic [4*DIGITS-1:0]   bcd_i,
  input  logic                  neg_i,
  input  logic                  ovr_i,
  input  logic                  lamp_i,
  output logic [7*DIGITS-1:0]   seg_o,
  output logic                  thou_o,
  output logic                  pol_o,
  output logic                  bp_o
);
  localparam int BCD_W = 4 * DIGITS;
  localparam int SEG_W = SEG_N * DIGITS;
  localparam int LIT_W = SEG_W + 2;

  logic             lat_thou, lat_neg, lat_ovr;
  logic [BCD_W-1:0] lat_bcd;
  logic [SEG_W-1:0] dig_seg;
  logic [LIT_W-1:0] lit, drv;
  logic             bp_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_thou <= 1'b0;
      lat_neg  <= 1'b0;
      lat_ovr  <= 1'b0;
      lat_bcd  <= '1;  // all codes 15: blank
    end else if (load_i) begin
      lat_thou <= thou_i;
      lat_neg  <= neg_i;
      lat_ovr  <= ovr_i;
      lat_bcd  <= bcd_i;
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    lcd_digit_dec u_dec (
      .code_i (lat_bcd[4*g +: 4]),
      .blank_i(lat_ovr),
      .seg_o  (dig_seg[SEG_N*g +: SEG_N])
    );
  end

  assign lit = {lat_neg, lat_thou | lat_ovr, dig_seg};

  lcd_bp_div #(.DIV(DIV)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bp_nxt_o(bp_nxt),
    .bp_o    (bp_o)
  );

  lcd_phase_drv #(.W(LIT_W)) u_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lit_i   (lit),
    .bp_nxt_i(bp_nxt),
    .lamp_i  (lamp_i),
    .drv_o   (drv)
  );

  assign seg_o  = drv[SEG_W-1:0];
  assign thou_o = drv[SEG_W];
  assign pol_o  = drv[SEG_W+1];
endmodule

// File: rtl/lcd_static_drv_chk.sv
`timescale 1ns/1ps
module lcd_static_drv_chk #(
  parameter int DIGITS = 3,
  parameter int DIV    = 800
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                load_i,
  input logic                ovr_i,
  input logic                lamp_i,
  input logic [7*DIGITS-1:0] seg_o,
  input logic                thou_o,
  input logic                pol_o,
  input logic                bp_o
);
  localparam int HALF  = DIV / 2;
  localparam int HW    = $clog2(HALF + 1) + 1;
  localparam int SEG_W = 7 * DIGITS;

  logic [HW-1:0] hold_q;
  logic          bp_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= '0;
      bp_last_q <= 1'b0;
    end else begin
      hold_q    <= (bp_o != bp_last_q) ? HW'(1) : hold_q + 1'b1;
      bp_last_q <= bp_o;
    end
  end

  p_bp_half_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_o != $past(bp_o)) |-> (hold_q == HW'(HALF)));

  p_bp_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q <= HW'(HALF));

  p_lamp_static_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(lamp_i)) |-> ((&seg_o) && thou_o && pol_o));

  p_ovr_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(rst_ni) && $past(load_i, 2) && $past(ovr_i, 2)
     && !$past(load_i) && !$past(lamp_i))
    |-> ((seg_o == {SEG_W{bp_o}}) && (thou_o == !bp_o)));

  p_same_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(rst_ni) && !$past(load_i, 2) && !$past(lamp_i)
     && !$past(lamp_i, 2) && (bp_o != $past(bp_o)))
    |-> ((seg_o == ~$past(seg_o)) && (thou_o != $past(thou_o)) && (pol_o != $past(pol_o))));

  p_hold_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(rst_ni) && !$past(load_i, 2) && !$past(lamp_i)
     && !$past(lamp_i, 2) && (bp_o == $past(bp_o)))
    |-> ($stable(seg_o) && $stable(thou_o) && $stable(pol_o)));

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_low_r10: assert (!bp_o && seg_o == '0 && !thou_o && !pol_o);
    end
  end
endmodule

bind lcd_static_drv lcd_static_drv_chk #(.DIGITS(DIGITS), .DIV(DIV)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .load_i(load_i),
  .ovr_i (ovr_i),
  .lamp_i(lamp_i),
  .seg_o (seg_o),
  .thou_o(thou_o),
  .pol_o (pol_o),
  .bp_o  (bp_o)
);

// File: tb/lcd_static_drv_test.sv
`timescale 1ns/1ps
module lcd_static_drv_test;
  localparam int DIGITS = 3;
  localparam int DIV    = 800;
  localparam int HALF   = DIV / 2;

  logic        clk_i = 1'b0;
  logic        rst_ni, load_i, thou_i, neg_i, ovr_i, lamp_i;
  logic [11:0] bcd_i;
  logic [20:0] seg_o;
  logic        thou_o, pol_o, bp_o;

  lcd_static_drv #(.DIGITS(DIGITS), .DIV(DIV)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .thou_i(thou_i),
    .bcd_i(bcd_i), .neg_i(neg_i), .ovr_i(ovr_i), .lamp_i(lamp_i),
    .seg_o(seg_o), .thou_o(thou_o), .pol_o(pol_o), .bp_o(bp_o)
  );

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    logic        lamp;
    logic [22:0] lit;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_err = 0, done_cnt = 0;

  logic       m_thou = 1'b0, m_neg = 1'b0, m_ovr = 1'b0;
  logic [3:0] m_d2 = 4'hF, m_d1 = 4'hF, m_d0 = 4'hF;

  function automatic logic [6:0] pat(input logic [3:0] c);
    case (c)
      4'd0: pat = 7'h3F; 4'd1: pat = 7'h06; 4'd2: pat = 7'h5B;
      4'd3: pat = 7'h4F; 4'd4: pat = 7'h66; 4'd5: pat = 7'h6D;
      4'd6: pat = 7'h7D; 4'd7: pat = 7'h07; 4'd8: pat = 7'h7F;
      4'd9: pat = 7'h6F; default: pat = 7'h00;
    endcase
  endfunction

  function automatic logic [22:0] model_lit();
    if (m_ovr) model_lit = {m_neg, 1'b1, 21'b0};
    else       model_lit = {m_neg, m_thou, pat(m_d2), pat(m_d1), pat(m_d0)};
  endfunction

  task automatic check(input item_t it, input string tag);
    logic [22:0] exp_v, act_v;
    exp_v = it.lamp ? '1 : (it.lit ^ {23{bp_o}});
    act_v = {pol_o, thou_o, seg_o};
    n_chk++;
    if (act_v !== exp_v) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h bp=%b", tag, act_v, exp_v, bp_o);
    end
  endtask

  task automatic expect_eq(input logic [31:0] act, input logic [31:0] exp_v, input string tag);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp_v);
    end
  endtask

  task automatic apply(input logic th, input logic [3:0] d2, d1, d0,
                       input logic ng, ov, lp, st, input string tag);
    item_t it;
    int    target;
    @(negedge clk_i);
    thou_i = th; bcd_i = {d2, d1, d0}; neg_i = ng; ovr_i = ov;
    lamp_i = lp; load_i = st;
    if (st) begin
      m_thou = th; m_d2 = d2; m_d1 = d1; m_d0 = d0; m_neg = ng; m_ovr = ov;
    end
    @(negedge clk_i);
    load_i = 1'b0;
    @(negedge clk_i);
    it.lamp = lp; it.lit = model_lit(); it.tag = tag;
    target = done_cnt + 1;
    q.push_back(it);
    wait (done_cnt == target);
  endtask

  // monitor: checks each item on the current phase and right after the next bp toggle
  initial begin
    item_t it;
    logic  bp0;
    forever begin
      wait (q.size() != 0);
      it  = q.pop_front();
      bp0 = bp_o;
      check(it, it.tag);
      do @(negedge clk_i); while (bp_o == bp0);
      check(it, {it.tag, " R11 after toggle"});
      done_cnt++;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    rst_ni = 1'b0; load_i = 1'b0; thou_i = 1'b0; bcd_i = '0;
    neg_i = 1'b0; ovr_i = 1'b0; lamp_i = 1'b0;
    repeat (3) @(negedge clk_i);
    expect_eq({bp_o, thou_o, pol_o, 21'(seg_o)}, 32'd0, "R10 outputs low in reset");
    rst_ni = 1'b1;

    // R1: half periods
    while (bp_o !== 1'b1) @(negedge clk_i);
    n = 1;
    forever begin
      @(negedge clk_i);
      if (bp_o) n++; else break;
    end
    expect_eq(n, HALF, "R1 high half-period");
    n = 1;
    forever begin
      @(negedge clk_i);
      if (!bp_o) n++; else break;
    end
    expect_eq(n, HALF, "R1 low half-period");

    apply(0, 4'h1, 4'h2, 4'h3, 0, 0, 0, 0, "R10 blank after reset");
    apply(1, 4'h1, 4'h2, 4'h3, 0, 0, 0, 1, "R3 R5 R2 reading 1123");
    apply(0, 4'h4, 4'h5, 4'h6, 1, 0, 0, 1, "R3 R6 reading -456");
    apply(0, 4'h7, 4'h8, 4'h9, 0, 0, 0, 1, "R3 R2 reading 789");
    apply(1, 4'h0, 4'h0, 4'h0, 1, 0, 0, 1, "R3 R5 R6 reading -1000");
    apply(0, 4'hA, 4'hC, 4'hF, 0, 0, 0, 1, "R4 codes A C F blank");
    apply(1, 4'hB, 4'hD, 4'hE, 0, 0, 0, 1, "R4 codes B D E blank");
    apply(0, 4'h9, 4'h9, 4'h9, 1, 1, 0, 1, "R7 overrange negative");
    apply(1, 4'h2, 4'h3, 4'h4, 0, 1, 0, 1, "R7 overrange positive");
    apply(0, 4'h5, 4'h0, 4'h2, 0, 0, 0, 1, "R9 load 502");
    apply(1, 4'h8, 4'h8, 4'h8, 1, 1, 0, 0, "R9 no strobe ignored");
    apply(0, 4'h0, 4'h0, 4'h0, 0, 0, 1, 0, "R8 lamp test static");
    apply(0, 4'h0, 4'h0, 4'h0, 0, 0, 0, 0, "R8 lamp release restores");
    apply(0, 4'h6, 4'h0, 4'h7, 1, 0, 0, 1, "R3 R9 reading -607");
    finish_run();
  end
endmodule